// File: doc/BRIEF.md
# Two-level segment and page address translator

This block turns a virtual address, given as a segment number plus a word index inside that segment, into a physical word address. It first reads a per-process descriptor table, whose location and entry count come from a base register. From the descriptor it checks that the segment is present, that the index is within the segment length, and that the requested access type is allowed. Only after those checks pass does it read the segment's page-table word. That word supplies the physical frame number, or reports that the page is missing.

A processor hands one request at a time to the block over a valid/ready interface. It receives exactly one single-cycle response for each request. The response holds either the physical address or one fault code. Table reads go out through a read port with a valid/ready request and read data that returns a fixed number of cycles later. Servicing faults, choosing pages to replace and caching translations all belong to other blocks.

Top module: `segpage_xlate`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0.
- R2: If the segment number is not less than `dbr_count`, the block responds with fault code 1 and issues no memory read.
- R3: The descriptor word is read from `dbr_base + seg`. If its bit 47 (missing flag) is 1, the block responds with fault code 2 and does not read the page table.
- R4: The segment length is held in descriptor bits [42:24]. A word index greater than or equal to the length gives fault code 3, and no page-table read takes place.
- R5: The rights bits are bit 43 (read), bit 44 (write) and bit 45 (execute). A request of kind 0 (read), 1 (write) or 2 (execute) whose bit is clear gives fault code 4, and so does a request of kind 3 in every case. The rights check is made only after the bounds check passes, and no page-table read follows a rights fault.
- R6: The page-table word is read from the page-table base (descriptor bits [23:0]) plus the page number, which is the word index divided by 1024. If bit 47 of that word is 1, the block responds with fault code 5.
- R7: On success the fault code is 0. The physical address is the frame number (page-table word bits [13:0]) shifted left by 10 bits, with the low 10 bits of the word index placed below it.
- R8: Each accepted request gets exactly one response, and `rsp_valid` is high for one cycle only. A faulted response carries physical address 0. `req_ready` stays low from the cycle a request is accepted until its response has been given.
- R9: `mem_req_valid` stays high with a stable address until `mem_req_ready` is seen. Read data is taken exactly `RD_LAT` cycles after the handshake, and only one read is outstanding at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbr_base | input | 24 | Physical address of the descriptor table |
| dbr_count | input | 19 | Number of descriptor table entries |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_seg | input | 18 | Segment number |
| req_idx | input | 18 | Word index within the segment |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_fault | output | 3 | Fault code, 0 when the translation succeeds |
| rsp_paddr | output | 24 | Physical word address |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 24 | Table word address |
| mem_rdata | input | 48 | Read data, valid RD_LAT cycles after the handshake |

## Verification
Four segments are set up to cover the cases: a present read/write segment, a missing segment, an execute-only segment whose length is exactly one page, and a read-only segment with a missing page. Each request targets one point where the checks could run in the wrong order. An index equal to the length separates a bounds fault from an off-by-one pass. A write to a missing page must give a rights fault, not a page fault. For every response the bench counts the table reads, so a page-table read after an early fault is caught. Requests using the largest frame number and the last offset in a page show whether the frame and offset are joined correctly, and a stalling memory-ready pattern exercises the read handshake.

// File: rtl/sx_pkg.sv
package sx_pkg;
   typedef enum logic [2:0] {
      FLT_NONE     = 3'd0,
      FLT_SEGNUM   = 3'd1,
      FLT_SEGMISS  = 3'd2,
      FLT_BOUND    = 3'd3,
      FLT_ACCESS   = 3'd4,
      FLT_PAGEMISS = 3'd5
   } sx_fault_e;

   typedef enum logic [1:0] {
      KIND_RD  = 2'd0,
      KIND_WR  = 2'd1,
      KIND_EX  = 2'd2,
      KIND_RSV = 2'd3
   } sx_kind_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_DESC,
      ST_CHECK,
      ST_RD_PTW,
      ST_RESPOND
   } sx_state_e;
endpackage

// File: rtl/sx_memrd.sv
module sx_memrd #(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 48,
   parameter int RD_LAT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic [ADDR_W-1:0] issue_addr,
   output logic              done,
   output logic [DATA_W-1:0] data,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam int CNT_W = $clog2(RD_LAT + 1);

   logic              waiting_q;
   logic              done_q;
   logic [DATA_W-1:0] data_q;
   logic              fire;
   logic              land;

   assign mem_req_valid = issue && !waiting_q && !done_q;
   assign mem_req_addr  = issue_addr;
   assign fire          = mem_req_valid && mem_req_ready;

   generate
      if (RD_LAT < 1) begin : g_bad_lat
         initial $error("sx_memrd: RD_LAT must be at least 1");
      end
      if (RD_LAT == 1) begin : g_lat_one
         assign land = waiting_q;
      end else begin : g_lat_cnt
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)         cnt_q <= '0;
            else if (fire)      cnt_q <= CNT_W'(1);
            else if (waiting_q) cnt_q <= cnt_q + 1'b1;
         end
         assign land = waiting_q && (cnt_q == CNT_W'(RD_LAT));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         waiting_q <= 1'b0;
         done_q    <= 1'b0;
         data_q    <= '0;
      end else begin
         if (fire)      waiting_q <= 1'b1;
         else if (land) waiting_q <= 1'b0;
         done_q <= land;
         if (land) data_q <= mem_rdata;
      end
   end

   assign done = done_q;
   assign data = data_q;

   // R9
   hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   // R9
   one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !mem_req_valid);
endmodule

// File: rtl/sx_sdw_check.sv
module sx_sdw_check
   import sx_pkg::*;
#(
   parameter int DATA_W = 48,
   parameter int PA_W   = 24,
   parameter int IDX_W  = 18,
   parameter int OFF_W  = 10
) (
   input  logic [DATA_W-1:0] sdw,
   input  logic [IDX_W-1:0]  idx,
   input  logic [1:0]        kind,
   output sx_fault_e         fault,
   output logic [PA_W-1:0]   pt_addr
);
   localparam int LEN_W   = IDX_W + 1;
   localparam int LEN_LSB = PA_W;
   localparam int ACC_LSB = PA_W + LEN_W;
   localparam int PG_W    = IDX_W - OFF_W;

   generate
      if (DATA_W < ACC_LSB + 4) begin : g_bad_w
         initial $error("sx_sdw_check: DATA_W too narrow for descriptor layout");
      end
   endgenerate

   logic             seg_missing;
   logic [LEN_W-1:0] seg_len;
   logic [2:0]       rights;
   logic             allowed;
   logic [PG_W-1:0]  page;

   assign seg_missing = sdw[DATA_W-1];
   assign seg_len     = sdw[LEN_LSB +: LEN_W];
   assign rights      = sdw[ACC_LSB +: 3];
   assign page        = idx[IDX_W-1:OFF_W];
   assign pt_addr     = sdw[PA_W-1:0] + PA_W'(page);

   always_comb begin
      case (sx_kind_e'(kind))
         KIND_RD: allowed = rights[0];
         KIND_WR: allowed = rights[1];
         KIND_EX: allowed = rights[2];
         default: allowed = 1'b0;
      endcase
   end

   always_comb begin
      if (seg_missing)                  fault = FLT_SEGMISS;
      else if ({1'b0, idx} >= seg_len)  fault = FLT_BOUND;
      else if (!allowed)                fault = FLT_ACCESS;
      else                              fault = FLT_NONE;
   end
endmodule

// File: rtl/sx_ptw_eval.sv
module sx_ptw_eval #(
   parameter int DATA_W = 48,
   parameter int PA_W   = 24,
   parameter int OFF_W  = 10
) (
   input  logic [DATA_W-1:0] ptw,
   input  logic [OFF_W-1:0]  offset,
   output logic              missing,
   output logic [PA_W-1:0]   paddr
);
   localparam int FRAME_W = PA_W - OFF_W;

   generate
      if (DATA_W < FRAME_W + 1) begin : g_bad_w
         initial $error("sx_ptw_eval: DATA_W too narrow for page word");
      end
   endgenerate

   assign missing = ptw[DATA_W-1];
   assign paddr   = {ptw[FRAME_W-1:0], offset};
endmodule

// File: rtl/segpage_xlate.sv
module segpage_xlate
   import sx_pkg::*;
#(
   parameter int SEG_W  = 18,
   parameter int IDX_W  = 18,
   parameter int OFF_W  = 10,
   parameter int PA_W   = 24,
   parameter int DATA_W = 48,
   parameter int RD_LAT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PA_W-1:0]   dbr_base,
   input  logic [SEG_W:0]    dbr_count,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [SEG_W-1:0]  req_seg,
   input  logic [IDX_W-1:0]  req_idx,
   input  logic [1:0]        req_kind,
   output logic              rsp_valid,
   output logic [2:0]        rsp_fault,
   output logic [PA_W-1:0]   rsp_paddr,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [PA_W-1:0]   mem_req_addr,
   input  logic [DATA_W-1:0] mem_rdata
);
   generate
      if (OFF_W >= IDX_W || OFF_W >= PA_W) begin : g_bad_off
         initial $error("segpage_xlate: OFF_W must be below IDX_W and PA_W");
      end
      if (SEG_W > PA_W) begin : g_bad_seg
         initial $error("segpage_xlate: SEG_W must fit in PA_W");
      end
   endgenerate

   sx_state_e         state_q;
   logic [IDX_W-1:0]  idx_q;
   logic [1:0]        kind_q;
   logic [PA_W-1:0]   desc_addr_q;
   logic [PA_W-1:0]   ptw_addr_q;
   logic [DATA_W-1:0] sdw_q;
   sx_fault_e         fault_q;
   logic [PA_W-1:0]   paddr_q;

   logic              rd_issue;
   logic [PA_W-1:0]   rd_addr;
   logic              rd_done;
   logic [DATA_W-1:0] rd_data;
   sx_fault_e         chk_fault;
   logic [PA_W-1:0]   chk_pt_addr;
   logic              pg_missing;
   logic [PA_W-1:0]   pg_paddr;
   logic              accept;

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign rd_issue  = (state_q == ST_RD_DESC) || (state_q == ST_RD_PTW);
   assign rd_addr   = (state_q == ST_RD_PTW) ? ptw_addr_q : desc_addr_q;

   sx_memrd #(.ADDR_W(PA_W), .DATA_W(DATA_W), .RD_LAT(RD_LAT)) i_memrd (
      .clk           (clk),
      .rst_n         (rst_n),
      .issue         (rd_issue),
      .issue_addr    (rd_addr),
      .done          (rd_done),
      .data          (rd_data),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_addr  (mem_req_addr),
      .mem_rdata     (mem_rdata)
   );

   sx_sdw_check #(.DATA_W(DATA_W), .PA_W(PA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) i_sdw_check (
      .sdw     (sdw_q),
      .idx     (idx_q),
      .kind    (kind_q),
      .fault   (chk_fault),
      .pt_addr (chk_pt_addr)
   );

   sx_ptw_eval #(.DATA_W(DATA_W), .PA_W(PA_W), .OFF_W(OFF_W)) i_ptw_eval (
      .ptw     (rd_data),
      .offset  (idx_q[OFF_W-1:0]),
      .missing (pg_missing),
      .paddr   (pg_paddr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         idx_q       <= '0;
         kind_q      <= '0;
         desc_addr_q <= '0;
         ptw_addr_q  <= '0;
         sdw_q       <= '0;
         fault_q     <= FLT_NONE;
         paddr_q     <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  idx_q       <= req_idx;
                  kind_q      <= req_kind;
                  desc_addr_q <= dbr_base + PA_W'(req_seg);
                  paddr_q     <= '0;
                  fault_q     <= FLT_NONE;
                  if ({1'b0, req_seg} >= dbr_count) begin
                     fault_q <= FLT_SEGNUM;
                     state_q <= ST_RESPOND;
                  end else begin
                     state_q <= ST_RD_DESC;
                  end
               end
            end
            ST_RD_DESC: begin
               if (rd_done) begin
                  sdw_q   <= rd_data;
                  state_q <= ST_CHECK;
               end
            end
            ST_CHECK: begin
               if (chk_fault != FLT_NONE) begin
                  fault_q <= chk_fault;
                  state_q <= ST_RESPOND;
               end else begin
                  ptw_addr_q <= chk_pt_addr;
                  state_q    <= ST_RD_PTW;
               end
            end
            ST_RD_PTW: begin
               if (rd_done) begin
                  if (pg_missing) fault_q <= FLT_PAGEMISS;
                  else            paddr_q <= pg_paddr;
                  state_q <= ST_RESPOND;
               end
            end
            ST_RESPOND: state_q <= ST_IDLE;
            default:    state_q <= ST_IDLE;
         endcase
      end
   end

   assign rsp_valid = (state_q == ST_RESPOND);
   assign rsp_fault = fault_q;
   assign rsp_paddr = paddr_q;

   // R8
   rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R8
   busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !req_ready);

   // R4
   early_fault_no_ptw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_CHECK && chk_fault != FLT_NONE) |=> (rsp_valid && !mem_req_valid));

   // R8
   fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault != 3'd0) |-> (rsp_paddr == '0));
endmodule

// File: tb/test_segpage_xlate.sv
module test_segpage_xlate;
   localparam int RD_LAT = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] dbr_base = 24'd16;
   logic [18:0] dbr_count = 19'd4;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [17:0] req_seg = '0;
   logic [17:0] req_idx = '0;
   logic [1:0]  req_kind = '0;
   logic        rsp_valid;
   logic [2:0]  rsp_fault;
   logic [23:0] rsp_paddr;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [23:0] mem_req_addr;
   logic [47:0] mem_rdata;

   always #10 clk = ~clk;

   segpage_xlate #(.RD_LAT(RD_LAT)) i_segpage_xlate (
      .clk, .rst_n, .dbr_base, .dbr_count, .req_valid, .req_ready,
      .req_seg, .req_idx, .req_kind, .rsp_valid, .rsp_fault, .rsp_paddr,
      .mem_req_valid, .mem_req_ready, .mem_req_addr, .mem_rdata
   );

   logic [47:0] mem [0:255];
   logic [47:0] pipe [RD_LAT];
   int          rd_total = 0;
   int          rd_seen  = 0;
   int          n_run = 0;
   int          n_fail = 0;
   int          cyc = 0;
   bit          finished = 0;

   assign mem_rdata = pipe[RD_LAT-1];

   always @(posedge clk) begin
      pipe[0] <= (mem_req_valid && mem_req_ready) ? mem[mem_req_addr[7:0]] : 48'hDEAD_DEAD_DEAD;
      for (int i = 1; i < RD_LAT; i++) pipe[i] <= pipe[i-1];
      if (mem_req_valid && mem_req_ready) rd_total <= rd_total + 1;
   end

   always @(negedge clk) begin
      cyc <= cyc + 1;
      mem_req_ready <= ((cyc % 5) != 1) && ((cyc % 5) != 2);
   end

   typedef struct {
      logic [2:0]  fault;
      logic [23:0] paddr;
      int          reads;
      string       tag;
   } exp_t;

   exp_t sb[$];

   function automatic exp_t model(logic [17:0] seg, logic [17:0] idx, logic [1:0] kind, string tag);
      exp_t e;
      logic [47:0] sdw, pte;
      logic        ok;
      e.tag = tag; e.paddr = '0; e.reads = 0; e.fault = 3'd0;
      if ({1'b0, seg} >= dbr_count) begin e.fault = 3'd1; return e; end
      sdw = mem[8'(dbr_base + 24'(seg))]; e.reads = 1;
      if (sdw[47]) begin e.fault = 3'd2; return e; end
      if ({1'b0, idx} >= sdw[42:24]) begin e.fault = 3'd3; return e; end
      case (kind)
         2'd0: ok = sdw[43];
         2'd1: ok = sdw[44];
         2'd2: ok = sdw[45];
         default: ok = 1'b0;
      endcase
      if (!ok) begin e.fault = 3'd4; return e; end
      pte = mem[8'(sdw[23:0] + 24'(idx[17:10]))]; e.reads = 2;
      if (pte[47]) begin e.fault = 3'd5; return e; end
      e.paddr = {pte[13:0], idx[9:0]};
      return e;
   endfunction

   task automatic check(bit ok, string msg);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s", msg);
      end
   endtask

   task automatic send(logic [17:0] seg, logic [17:0] idx, logic [1:0] kind, string tag);
      sb.push_back(model(seg, idx, kind, tag));
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_seg = seg; req_idx = idx; req_kind = kind; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (sb.size() == 0) begin
            check(0, $sformatf("R8 unexpected response fault=%0d act=1 exp=0", rsp_fault));
         end else begin
            exp_t e;
            int   rd;
            e  = sb.pop_front();
            rd = rd_total - rd_seen;
            rd_seen = rd_total;
            check(rsp_fault == e.fault && rsp_paddr == e.paddr && rd == e.reads,
                  $sformatf("%s act fault=%0d paddr=%h reads=%0d exp fault=%0d paddr=%h reads=%0d",
                            e.tag, rsp_fault, rsp_paddr, rd, e.fault, e.paddr, e.reads));
         end
      end
   end

   function automatic logic [47:0] mk_sdw(bit miss, bit x, bit w, bit r, logic [18:0] len, logic [23:0] pt);
      return {miss, 1'b0, x, w, r, len, pt};
   endfunction

   function automatic logic [47:0] mk_ptw(bit miss, logic [13:0] frame);
      return {miss, 33'd0, frame};
   endfunction

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL R8 watchdog expired act=hung exp=done");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = mk_ptw(1'b1, 14'd0);
      for (int i = 0; i < RD_LAT; i++) pipe[i] = '0;
      mem[16] = mk_sdw(0, 0, 1, 1, 19'd3000, 24'd64);
      mem[17] = mk_sdw(1, 1, 1, 1, 19'd4096, 24'd200);
      mem[18] = mk_sdw(0, 1, 0, 0, 19'd1024, 24'd96);
      mem[19] = mk_sdw(0, 0, 0, 1, 19'd2048, 24'd128);
      mem[64]  = mk_ptw(0, 14'd5);
      mem[65]  = mk_ptw(0, 14'h3FFF);
      mem[66]  = mk_ptw(1, 14'd1);
      mem[96]  = mk_ptw(0, 14'd7);
      mem[128] = mk_ptw(0, 14'd9);
      mem[129] = mk_ptw(1, 14'd2);

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b1, $sformatf("R1 req_ready act=%b exp=1", req_ready));
      check(rsp_valid == 1'b0, $sformatf("R1 rsp_valid act=%b exp=0", rsp_valid));
      check(mem_req_valid == 1'b0, $sformatf("R1 mem_req_valid act=%b exp=0", mem_req_valid));

      send(18'd0, 18'd10, 2'd0, "R7 basic read");
      send(18'd0, 18'd2047, 2'd1, "R7 r9_ max frame last offset");
      send(18'd0, 18'd2999, 2'd0, "R6 missing page");
      send(18'd0, 18'd3000, 2'd0, "R4 index equal length");
      send(18'd0, 18'd5, 2'd2, "R5 exec denied");
      send(18'd1, 18'd0, 2'd0, "R3 missing segment");
      send(18'd4, 18'd0, 2'd0, "R2 seg equals count");
      send(18'h3FFFF, 18'd0, 2'd0, "R2 max seg");
      send(18'd2, 18'd1023, 2'd2, "R7 exec last word");
      send(18'd2, 18'd1024, 2'd2, "R4 one page boundary");
      send(18'd2, 18'd0, 2'd0, "R5 read on exec-only");
      send(18'd3, 18'd100, 2'd0, "R7 read-only ok");
      send(18'd3, 18'd1500, 2'd0, "R6 page missing ro");
      send(18'd3, 18'd1500, 2'd1, "R5 rights before page");
      send(18'd0, 18'd0, 2'd3, "R5 reserved kind");
      @(negedge clk);
      dbr_count = 19'd0;
      send(18'd0, 18'd0, 2'd0, "R2 empty table");

      while (sb.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
      check(rsp_valid == 1'b0 && req_ready == 1'b1,
            $sformatf("R8 idle after last act=%b%b exp=01", rsp_valid, req_ready));
      finish_run();
   end
endmodule